// File: doc/BRIEF.md
# Cascadable presettable binary counter

The block is a synchronous binary up-counter built from 4-bit slices. Each slice can be loaded in parallel from a data input, cleared by an active-low clear, and advanced when two active-high count enables are both high. A slice raises its ripple-carry output when it holds all ones and its carry-gating enable is high. The carry does not depend on the other enable.

The top level chains `NUM_STAGES` slices into one counter of `4*NUM_STAGES` bits. The shared enable `enp_i` goes to every slice. The carry-gating enable of stage 0 comes from `ent_i`, and each later stage takes the ripple carry of the stage below it. The chain therefore counts as one wide binary counter and raises its final carry only when the whole count is all ones. A parameter chooses between a clear that acts on the clock edge and one that acts at once, independent of the clock. `rst_ni` is the chip-level asynchronous reset.

Top module: `cnt_chain`

## Requirements
- R1: While `rst_ni` is low, `count_o` is zero, whatever the clock is doing.
- R2: With `clr_ni` and `load_ni` high and both `enp_i` and `ent_i` high, every rising edge adds one to `count_o`. All bits update on the same edge, and the all-ones value wraps to zero.
- R3: With `clr_ni` and `load_ni` high and either enable low, `count_o` holds its value across the edge.
- R4: With `clr_ni` high and `load_ni` low, the next rising edge copies `data_i` into `count_o`, whatever the state of `enp_i` and `ent_i`.
- R5: Clear outranks load and counting. With `ASYNC_CLR=0`, `count_o` becomes zero on a rising edge at which `clr_ni` is low, and not before that edge.
- R6: With `ASYNC_CLR=1`, `clr_ni` going low forces `count_o` to zero immediately, between clock edges, and holds it there while `clr_ni` stays low.
- R7: `carry_o` is high exactly when `ent_i` is high and `count_o` is all ones. It is independent of `enp_i`.
- R8: Each stage's carry advances the next 4-bit stage, so a low stage wrapping from 15 to 0 increments the stage above it in the same edge.
- R9: The sequence clear, preset to twelve, then count gives 13, 14, 15 in the low slice and continues across the slice boundary. Dropping an enable afterwards freezes the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Counter clear, active low, style set by ASYNC_CLR |
| load_ni | input | 1 | Parallel load, active low, synchronous |
| enp_i | input | 1 | Count enable shared by all stages |
| ent_i | input | 1 | Count enable of stage 0, also gates the carry |
| data_i | input | 4*NUM_STAGES | Parallel load value |
| count_o | output | 4*NUM_STAGES | Current count |
| carry_o | output | 1 | Final ripple carry |

## Verification
The clocked properties assume that in asynchronous-clear mode any low pulse on `clr_ni` stays low across at least one rising edge. A pulse that starts and ends between two edges would defeat the one-cycle load and increment checks. The stimulus changes every input at the falling edge. The mid-cycle clear is dropped after a falling edge and released only at a later falling edge, so it always spans a rising edge. Two instances run the same stimulus, one per clear style, and only the mid-cycle check expects them to differ.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  localparam int unsigned SLICE_W = 4;
  typedef logic [SLICE_W-1:0] nib_t;
  typedef enum logic [1:0] {OP_HOLD, OP_INC, OP_LOAD, OP_CLR} op_e;
endpackage

// File: rtl/cnt_slice_ctl.sv
`timescale 1ns/1ps
module cnt_slice_ctl
  import cnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic clr_ni,
  input  logic load_ni,
  input  logic enp_i,
  input  logic ent_i,
  output op_e  op_o
);
  // priority: clear, load, count
  always_comb begin
    if (SYNC_CLR && !clr_ni)  op_o = OP_CLR;
    else if (!load_ni)        op_o = OP_LOAD;
    else if (enp_i && ent_i)  op_o = OP_INC;
    else                      op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_slice.sv
`timescale 1ns/1ps
module cnt_slice
  import cnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic load_ni,
  input  logic enp_i,
  input  logic ent_i,
  input  nib_t data_i,
  output nib_t q_o,
  output logic rc_o
);
  op_e  op;
  nib_t q_q, q_nxt;

  cnt_slice_ctl #(.SYNC_CLR(!ASYNC_CLR)) u_ctl (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .enp_i   (enp_i),
    .ent_i   (ent_i),
    .op_o    (op)
  );

  always_comb begin
    unique case (op)
      OP_CLR:  q_nxt = '0;
      OP_LOAD: q_nxt = data_i;
      OP_INC:  q_nxt = q_q + nib_t'(1);
      default: q_nxt = q_q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
        if (!rst_ni)      q_q <= '0;
        else if (!clr_ni) q_q <= '0;
        else              q_q <= q_nxt;
      end
    end else begin : g_sclr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '0;
        else         q_q <= q_nxt;
      end
    end
  endgenerate

  assign q_o  = q_q;
  assign rc_o = ent_i & (&q_q);
endmodule

// File: rtl/cnt_chain.sv
`timescale 1ns/1ps
module cnt_chain
  import cnt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 3,
  parameter bit          ASYNC_CLR  = 1'b0,
  localparam int unsigned CNT_W     = NUM_STAGES * SLICE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             enp_i,
  input  logic             ent_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);
  logic [NUM_STAGES:0] ent_chain;

  assign ent_chain[0] = ent_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_slice #(.ASYNC_CLR(ASYNC_CLR)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_ni  (clr_ni),
      .load_ni (load_ni),
      .enp_i   (enp_i),
      .ent_i   (ent_chain[k]),
      .data_i  (data_i[k*SLICE_W +: SLICE_W]),
      .q_o     (count_o[k*SLICE_W +: SLICE_W]),
      .rc_o    (ent_chain[k+1])
    );
  end

  assign carry_o = ent_chain[NUM_STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
`timescale 1ns/1ps
module cnt_chain_chk #(
  parameter int unsigned NUM_STAGES = 3,
  parameter bit          ASYNC_CLR  = 1'b0,
  localparam int unsigned CNT_W     = NUM_STAGES * 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic             enp_i,
  input logic             ent_i,
  input logic [CNT_W-1:0] data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             carry_o
);
  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && enp_i && ent_i) |=>
      (!clr_ni || count_o == ($past(count_o) + CNT_W'(1))));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(enp_i && ent_i)) |=> (!clr_ni || $stable(count_o)));

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> (!clr_ni || count_o == $past(data_i)));

  p_clr_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (count_o == '0));

  p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == (ent_i && (count_o == {CNT_W{1'b1}})));

  generate
    if (ASYNC_CLR) begin : g_async
      p_clr_now_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |-> (count_o == '0));
    end
  endgenerate
endmodule

bind cnt_chain cnt_chain_chk #(.NUM_STAGES(NUM_STAGES), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .load_ni (load_ni),
  .enp_i   (enp_i),
  .ent_i   (ent_i),
  .data_i  (data_i),
  .count_o (count_o),
  .carry_o (carry_o)
);

// File: tb/cnt_chain_tb.sv
`timescale 1ns/1ps
module cnt_chain_tb;
  localparam int W = 12;

  typedef struct packed {
    logic         clr_n;
    logic         load_n;
    logic         enp;
    logic         ent;
    logic [W-1:0] data;
    logic [W-1:0] exp_cnt;
    logic         exp_cy;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0}, // R5/R9 clear
    '{1'b1, 1'b0, 1'b1, 1'b1, 12'h00C, 12'h00C, 1'b0}, // R4/R9 preset 12
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h00D, 1'b0}, // R2/R9
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h00E, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h00F, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h010, 1'b0}, // R8 nibble wrap
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h011, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h012, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 12'h012, 1'b0}, // R3/R9 inhibit
    '{1'b1, 1'b1, 1'b1, 1'b0, 12'h000, 12'h012, 1'b0}, // R3
    '{1'b1, 1'b0, 1'b0, 1'b0, 12'hFFD, 12'hFFD, 1'b0}, // R4 load, enables low
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'hFFE, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'hFFF, 1'b1}, // R7
    '{1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b1}, // R7 enp ignored
    '{1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b0}, // R7 ent gates
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0}, // R2 wrap
    '{1'b1, 1'b0, 1'b1, 1'b1, 12'h0FF, 12'h0FF, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h100, 1'b0}, // R8 two-stage carry
    '{1'b0, 1'b0, 1'b1, 1'b1, 12'h5A3, 12'h000, 1'b0}, // R5 clear beats load
    '{1'b1, 1'b0, 1'b1, 1'b1, 12'h0EF, 12'h0EF, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'h0F0, 1'b0}  // R8
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr_n = 1'b1;
  logic         load_n = 1'b1;
  logic         enp = 1'b0;
  logic         ent = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] cnt_s, cnt_a;
  logic         cy_s, cy_a;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  cnt_chain #(.NUM_STAGES(3), .ASYNC_CLR(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .enp_i(enp), .ent_i(ent), .data_i(data), .count_o(cnt_s), .carry_o(cy_s)
  );

  cnt_chain #(.NUM_STAGES(3), .ASYNC_CLR(1'b1)) u_dut_async (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .enp_i(enp), .ent_i(ent), .data_i(data), .count_o(cnt_a), .carry_o(cy_a)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t,
                       input logic [W-1:0] d);
    @(negedge clk);
    clr_n = c; load_n = l; enp = p; ent = t; data = d;
  endtask

  initial begin
    // R1: reset state
    #1;
    check("R1 sync", cnt_s, '0);
    check("R1 async", cnt_a, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // table walk, same expectations for both clear styles
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].clr_n, VEC[i].load_n, VEC[i].enp, VEC[i].ent, VEC[i].data);
      @(posedge clk); #1;
      check($sformatf("R2-table row %0d sync cnt", i), cnt_s, VEC[i].exp_cnt);
      check($sformatf("R2-table row %0d async cnt", i), cnt_a, VEC[i].exp_cnt);
      check($sformatf("R7 row %0d sync carry", i), W'(cy_s), W'(VEC[i].exp_cy));
      check($sformatf("R7 row %0d async carry", i), W'(cy_a), W'(VEC[i].exp_cy));
    end

    // R6 / R5: clear dropped between edges
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h777);
    @(posedge clk); #1;
    check("R4 preload sync", cnt_s, 12'h777);
    load_n = 1'b1;
    @(negedge clk); #0.5;
    clr_n = 1'b0;
    #0.5;
    check("R6 async clear immediate", cnt_a, '0);
    check("R5 sync clear waits for edge", cnt_s, 12'h777);
    @(posedge clk); #1;
    check("R5 sync clear at edge", cnt_s, '0);
    check("R6 async held low", cnt_a, '0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    @(posedge clk); #1;
    check("R2 count after clear sync", cnt_s, 12'h001);
    check("R2 count after clear async", cnt_a, 12'h001);

    // R1: reset mid-cycle
    drive(1'b1, 1'b0, 1'b0, 1'b0, 12'hABC);
    @(posedge clk); #1;
    check("R4 load sync", cnt_s, 12'hABC);
    rst_n = 1'b0;
    #0.5;
    check("R1 mid-cycle sync", cnt_s, '0);
    check("R1 mid-cycle async", cnt_a, '0);
    @(posedge clk); #1;
    check("R1 held through edge", cnt_s, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule